// File: doc/BRIEF.md
# Ring Slave Time Alignment Unit

This block runs in every slave node of a one-way communication ring and keeps the node's free-running counter in step with the master's time base. At start-up a numbering word travels the ring. Each node takes the value it receives as its own position, then passes the word on with the value one higher. The same start-up pass delivers the mean link delay between neighbouring nodes, and the node stores that value once.

In each alignment round the node stamps its counter when the timing message arrives and again when the message leaves. The difference between the two stamps is the node's own pass-through time, and the node sends it downstream. The node also collects the pass-through times sent by the slaves ahead of it, together with the master's send time. From these it predicts the counter value it should have had on arrival. The signed difference between that prediction and its own arrival stamp is added to the counter in a single cycle. A slower enable pulse taken from the corrected counter lets modulators in different nodes switch together.

Top module: `ring_sync_top`

## Requirements
- R1: A numbering word (kind code 0) carrying value v sets the node position to v, and one cycle later the same word appears at the forward port with value v+1.
- R2: A receive strobe captures the counter value present in that cycle, and so does a transmit strobe. Two cycles after the transmit strobe, the node sends a pass-through word (kind code 3) holding transmit stamp minus receive stamp, provided no input word needs the forward port in that cycle.
- R3: Master-time words (kind 2), delay words (kind 1) and upstream pass-through words (kind 3) go out at the forward port unchanged, one cycle after they arrive. Each upstream pass-through value is added to a running sum.
- R4: The expected delay is the node position times the stored mean link delay plus the sum of upstream pass-through values. All arithmetic wraps modulo 2^32.
- R5: When a correction is applied, the next counter value is counter + 1 + (master time + expected delay − receive stamp), modulo 2^32, all in one cycle.
- R6: A correction is applied only once a receive stamp, a transmit stamp, a master-time word, a stored delay, a nonzero position and exactly position−1 upstream pass-through words are all present. In every other cycle the counter advances by exactly 1.
- R7: Only the first delay word after reset is stored. Later delay words have no effect on any correction.
- R8: The tick output is high exactly when the low TICK_LOG2 bits (default 4) of the counter are all zero.
- R9: The synced output rises in the cycle after the first correction and stays high until reset.
- R10: After reset the counter, position, synced and forward-valid outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxStamp | input | 1 | Timing message arrival strobe |
| txStamp | input | 1 | Timing message departure strobe |
| wordValid | input | 1 | Decoded word present |
| wordKind | input | 2 | 0 number, 1 delay, 2 master time, 3 pass-through |
| wordData | input | 32 | Word payload |
| localCount | output | 32 | Corrected local counter |
| syncTick | output | 1 | Slow aligned enable |
| synced | output | 1 | First correction done |
| nodeId | output | 8 | Learned ring position |
| fwdValid | output | 1 | Outgoing word present |
| fwdKind | output | 2 | Outgoing word kind |
| fwdData | output | 32 | Outgoing word payload |

## Verification
The assertions assume that within a round the receive strobe comes before the transmit strobe. They also assume that no word or strobe arrives in the cycle a correction is applied, and that no input word arrives in the cycle the node sends its own pass-through word. The bench keeps to these assumptions by leaving several idle cycles after every strobe and word. It runs rounds with two upstream nodes and with none, a round whose error is zero, and a round whose correction wraps the counter.

// File: rtl/ring_sync_pkg.sv
package ring_sync_pkg;
  localparam int CNT_W = 32;
  localparam int ID_W  = 8;

  typedef enum logic [1:0] {
    KIND_ID     = 2'd0,
    KIND_AVG    = 2'd1,
    KIND_MASTER = 2'd2,
    KIND_PASS   = 2'd3
  } wordKind_e;

  typedef struct packed {
    logic latchRx;
    logic latchTx;
    logic loadMaster;
    logic addPass;
    logic loadAvg;
    logic applyFix;
  } dpCtl_t;
endpackage

// File: rtl/ring_sync_datapath.sv
module ring_sync_datapath
  import ring_sync_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int IW = ID_W,
  parameter int TICK_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpCtl_t        ctl,
  input  logic [CW-1:0] wordData,
  input  logic [IW-1:0] nodeId,
  output logic [CW-1:0] count,
  output logic [CW-1:0] passTime,
  output logic          syncTick
);
  logic [CW-1:0] rxTime, txTime, masterTx, avgReg, passSum;
  logic [CW-1:0] expDelay, errVal;

  assign expDelay = CW'(nodeId) * avgReg + passSum;
  assign errVal   = masterTx + expDelay - rxTime;
  assign passTime = txTime - rxTime;
  assign syncTick = (count[TICK_LOG2-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      rxTime   <= '0;
      txTime   <= '0;
      masterTx <= '0;
      avgReg   <= '0;
      passSum  <= '0;
    end else begin
      if (ctl.applyFix) count <= count + CW'(1) + errVal;
      else              count <= count + CW'(1);
      if (ctl.latchRx)    rxTime   <= count;
      if (ctl.latchTx)    txTime   <= count;
      if (ctl.loadMaster) masterTx <= wordData;
      if (ctl.loadAvg)    avgReg   <= wordData;
      if (ctl.applyFix)     passSum <= '0;
      else if (ctl.addPass) passSum <= passSum + wordData;
    end
  end

  // R6: without a correction the counter steps by one
  a_r6_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.applyFix |=> count == $past(count) + CW'(1));

  // R7: stored delay changes only through its load strobe
  a_r7_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loadAvg |=> $stable(avgReg));
endmodule

// File: rtl/ring_sync_control.sv
module ring_sync_control
  import ring_sync_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int IW = ID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxStamp,
  input  logic          txStamp,
  input  logic          wordValid,
  input  logic [1:0]    wordKind,
  input  logic [CW-1:0] wordData,
  input  logic [CW-1:0] passTime,
  output dpCtl_t        ctl,
  output logic [IW-1:0] nodeId,
  output logic          synced,
  output logic          fwdValid,
  output logic [1:0]    fwdKind,
  output logic [CW-1:0] fwdData
);
  logic avgTaken, rxSeen, txSeen, masterSeen, ownPending, ready;
  logic [IW-1:0] passCount;
  logic isId, isAvg, isMaster, isPass;

  assign isId     = wordValid && (wordKind == KIND_ID);
  assign isAvg    = wordValid && (wordKind == KIND_AVG);
  assign isMaster = wordValid && (wordKind == KIND_MASTER);
  assign isPass   = wordValid && (wordKind == KIND_PASS);

  assign ready = rxSeen && txSeen && masterSeen && avgTaken && (nodeId != '0)
                 && (passCount == nodeId - IW'(1));

  always_comb begin
    ctl.latchRx    = rxStamp;
    ctl.latchTx    = txStamp;
    ctl.loadMaster = isMaster;
    ctl.addPass    = isPass;
    ctl.loadAvg    = isAvg && !avgTaken;
    ctl.applyFix   = ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nodeId     <= '0;
      avgTaken   <= 1'b0;
      rxSeen     <= 1'b0;
      txSeen     <= 1'b0;
      masterSeen <= 1'b0;
      passCount  <= '0;
      ownPending <= 1'b0;
      synced     <= 1'b0;
      fwdValid   <= 1'b0;
      fwdKind    <= '0;
      fwdData    <= '0;
    end else begin
      if (isId)  nodeId   <= wordData[IW-1:0];
      if (isAvg) avgTaken <= 1'b1;
      if (ready) begin
        rxSeen     <= 1'b0;
        txSeen     <= 1'b0;
        masterSeen <= 1'b0;
        passCount  <= '0;
        synced     <= 1'b1;
      end else begin
        if (rxStamp)  rxSeen     <= 1'b1;
        if (txStamp)  txSeen     <= 1'b1;
        if (isMaster) masterSeen <= 1'b1;
        if (isPass)   passCount  <= passCount + IW'(1);
      end
      if (wordValid) begin
        fwdValid <= 1'b1;
        fwdKind  <= wordKind;
        fwdData  <= isId ? wordData + CW'(1) : wordData;
        if (txStamp) ownPending <= 1'b1;
      end else if (ownPending) begin
        fwdValid   <= 1'b1;
        fwdKind    <= KIND_PASS;
        fwdData    <= passTime;
        ownPending <= txStamp;
      end else begin
        fwdValid <= 1'b0;
        fwdKind  <= '0;
        fwdData  <= '0;
        if (txStamp) ownPending <= 1'b1;
      end
    end
  end

  // R1: numbering word is forwarded incremented
  a_r1_id_forward: assert property (@(posedge clk) disable iff (!rst_n)
    isId |=> fwdValid && fwdKind == KIND_ID && fwdData == $past(wordData) + CW'(1));

  // R9: synced never drops once set
  a_r9_synced_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);

  // R6: a correction closes the round, so it never repeats back to back
  a_r6_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.applyFix |=> !ctl.applyFix && synced);

  // R7: the delay is taken once and stays taken
  a_r7_avg_once: assert property (@(posedge clk) disable iff (!rst_n)
    avgTaken |=> avgTaken && !ctl.loadAvg);
endmodule

// File: rtl/ring_sync_top.sv
module ring_sync_top
  import ring_sync_pkg::*;
#(
  parameter int TICK_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxStamp,
  input  logic             txStamp,
  input  logic             wordValid,
  input  logic [1:0]       wordKind,
  input  logic [CNT_W-1:0] wordData,
  output logic [CNT_W-1:0] localCount,
  output logic             syncTick,
  output logic             synced,
  output logic [ID_W-1:0]  nodeId,
  output logic             fwdValid,
  output logic [1:0]       fwdKind,
  output logic [CNT_W-1:0] fwdData
);
  dpCtl_t ctl;
  logic [CNT_W-1:0] passTime;

  ring_sync_control #(.CW(CNT_W), .IW(ID_W)) control_i (
    .clk(clk), .rst_n(rst_n), .rxStamp(rxStamp), .txStamp(txStamp),
    .wordValid(wordValid), .wordKind(wordKind), .wordData(wordData),
    .passTime(passTime), .ctl(ctl), .nodeId(nodeId), .synced(synced),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdData(fwdData)
  );

  ring_sync_datapath #(.CW(CNT_W), .IW(ID_W), .TICK_LOG2(TICK_LOG2)) datapath_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wordData(wordData), .nodeId(nodeId),
    .count(localCount), .passTime(passTime), .syncTick(syncTick)
  );
endmodule

// File: tb/ring_sync_tb.sv
module ring_sync_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxStamp = 1'b0, txStamp = 1'b0, wordValid = 1'b0;
  logic [1:0] wordKind = 2'd0;
  logic [31:0] wordData = 32'd0;
  logic [31:0] localCount, fwdData;
  logic syncTick, synced, fwdValid;
  logic [1:0] fwdKind;
  logic [7:0] nodeId;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  ring_sync_top dut_i (
    .clk(clk), .rst_n(rst_n), .rxStamp(rxStamp), .txStamp(txStamp),
    .wordValid(wordValid), .wordKind(wordKind), .wordData(wordData),
    .localCount(localCount), .syncTick(syncTick), .synced(synced),
    .nodeId(nodeId), .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdData(fwdData)
  );

  // behavioural reference
  logic [31:0] mCnt = 0, mRx = 0, mTx = 0, mMaster = 0, mAvg = 0, mSum = 0;
  logic [7:0]  mId = 0;
  int          mPass = 0;
  bit mAvgOk = 0, mRxOk = 0, mTxOk = 0, mMasterOk = 0, mSynced = 0, mOwn = 0;
  bit mFv = 0;
  logic [1:0]  mFk = 0;
  logic [31:0] mFd = 0;

  always @(posedge clk) begin
    logic [31:0] old;
    bit fire;
    old = mCnt;
    started = 1'b1;
    if (!rst_n) begin
      mCnt = 0; mRx = 0; mTx = 0; mMaster = 0; mAvg = 0; mSum = 0; mId = 0;
      mPass = 0; mAvgOk = 0; mRxOk = 0; mTxOk = 0; mMasterOk = 0;
      mSynced = 0; mOwn = 0; mFv = 0; mFk = 0; mFd = 0;
    end else begin
      fire = mRxOk && mTxOk && mMasterOk && mAvgOk && (mId != 0) && (mPass == int'(mId) - 1);
      if (fire) begin
        mCnt = old + 1 + (mMaster + mId * mAvg + mSum - mRx);
        mRxOk = 0; mTxOk = 0; mMasterOk = 0; mPass = 0; mSum = 0; mSynced = 1;
      end else mCnt = old + 1;
      if (wordValid) begin
        mFv = 1; mFk = wordKind;
        mFd = (wordKind == 2'd0) ? wordData + 1 : wordData;
        case (wordKind)
          2'd0: mId = wordData[7:0];
          2'd1: if (!mAvgOk) begin mAvg = wordData; mAvgOk = 1; end
          2'd2: begin mMaster = wordData; mMasterOk = 1; end
          default: begin mSum = mSum + wordData; mPass++; end
        endcase
      end else if (mOwn) begin
        mFv = 1; mFk = 2'd3; mFd = mTx - mRx; mOwn = 0;
      end else begin
        mFv = 0; mFk = 0; mFd = 0;
      end
      if (rxStamp) begin mRx = old; mRxOk = 1; end
      if (txStamp) begin mTx = old; mTxOk = 1; mOwn = 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(localCount == mCnt, "R4 R5 R6 R7 count", localCount, mCnt);
      chk(syncTick == (mCnt[3:0] == 4'd0), "R8 tick", 32'(syncTick), 32'(mCnt[3:0] == 4'd0));
      chk(synced == mSynced, "R9 synced", 32'(synced), 32'(mSynced));
      chk(nodeId == mId, "R1 nodeId", 32'(nodeId), 32'(mId));
      chk(fwdValid == mFv, "R1 R2 R3 fwdValid", 32'(fwdValid), 32'(mFv));
      if (mFv) begin
        chk(fwdKind == mFk, "R1 R2 R3 fwdKind", 32'(fwdKind), 32'(mFk));
        chk(fwdData == mFd, "R1 R2 R3 fwdData", fwdData, mFd);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sendWord(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk); wordValid = 1; wordKind = k; wordData = d;
    @(negedge clk); wordValid = 0; wordKind = 0; wordData = 0;
    idle(2);
  endtask
  task automatic pulseRx();
    @(negedge clk); rxStamp = 1; @(negedge clk); rxStamp = 0; idle(2);
  endtask
  task automatic pulseTx();
    @(negedge clk); txStamp = 1; @(negedge clk); txStamp = 0; idle(4);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(3);
    // R10 reset state
    chk(localCount == 0 && synced == 0 && nodeId == 0 && fwdValid == 0, "R10 reset", localCount, 0);
    rst_n = 1; idle(5);
    // R1 numbering as third node
    sendWord(2'd0, 32'd3);
    sendWord(2'd1, 32'd100);              // R7 first delay stored
    // round 1 with two upstream nodes (R2 R3 R4 R5)
    pulseRx(); sendWord(2'd2, 32'd5000);
    sendWord(2'd3, 32'd20); idle(10);
    // R6 incomplete round: still one pass word missing
    chk(synced == 0, "R6 no early fix", 32'(synced), 0);
    sendWord(2'd3, 32'd25); pulseTx(); idle(20);
    chk(synced == 1, "R9 synced after fix", 32'(synced), 1);
    // R7 later delay word ignored
    sendWord(2'd1, 32'd999);
    // round 2: zero error
    pulseRx(); pulseTx();
    sendWord(2'd3, 32'd7); sendWord(2'd3, 32'd9);
    sendWord(2'd2, mRx - (32'd300 + 32'd16)); idle(10);
    // round 3: wrap around
    pulseRx(); sendWord(2'd2, 32'hFFFF_FF00);
    sendWord(2'd3, 32'd1); sendWord(2'd3, 32'd2); pulseTx(); idle(300);
    // second reset: first slave, no upstream words
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(3);
    sendWord(2'd0, 32'd0); sendWord(2'd0, 32'd1);
    sendWord(2'd1, 32'd40);
    pulseRx(); sendWord(2'd2, 32'd12345); pulseTx(); idle(40);
    chk(synced == 1, "R9 first slave synced", 32'(synced), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule